// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Engine

This block is the slave side of a two-wire serial EEPROM, limited to write commands. It brings SCL, SDA and a write-control input into the system clock domain and finds START and STOP conditions, which are SDA transitions while SCL is high. It decodes a select byte and then takes two address bytes, most significant first. After that it accepts one data byte or a run of data bytes. It acknowledges each accepted byte by pulling SDA low during the ninth clock.

Data bytes are gathered in a 64-entry row buffer, indexed by the low six address bits. The buffer is written into the byte array only when a clean STOP closes the command. A repeated START, or a STOP that cuts a byte short, throws the buffered bytes away. When write-control is high at any point from START through the second address byte, the command is refused: data bytes get no acknowledge and the array keeps its contents. The array has 2^ADDR_W bytes. The default is 11 address bits; 14 gives the full 16K x 8. A combinational read port lets the array be inspected.

Top module: `eew_top`

## Requirements
- R1: A select byte is acknowledged only when its upper four bits are 1010 and its bit 0 is 0; bits 3 to 1 are ignored. Any other select byte gets no acknowledge, and neither do the bytes that follow it until the next START. Such a command leaves the array unchanged.
- R2: After an accepted select byte, exactly two address bytes follow, the most significant first. Both are acknowledged.
- R3: In a byte write, the single data byte is acknowledged and is stored at the received address once STOP arrives.
- R4: In a page write, each data byte is acknowledged, and successive bytes are stored at successive addresses.
- R5: Only the low six address bits advance during a page write, and they wrap within the 64-byte row. When more than 64 bytes are sent, later bytes overwrite the earlier ones at the same offset.
- R6: Received address bits 15 down to ADDR_W have no effect on which array entry is written.
- R7: If write-control is sampled high at any time from START up to and including the clock cycle in which the second address byte completes, every data byte gets a NoAck and the array is unchanged. Write-control rising after that cycle has no effect.
- R8: A repeated START discards the buffered bytes. So does a STOP that arrives after 2 to 8 bits of a data byte have been taken. In both cases the array is unchanged.
- R9: The array does not change before STOP. A committed write is complete within 72 clock cycles of SDA rising for STOP.
- R10: sda_oe is high only in an acknowledge slot. The slot runs from the SCL fall that ends bit 8 of an accepted byte to the SCL fall that ends bit 9.
- R11: After reset, sda_oe is low, and bits clocked before the first START get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| wc_i | input | 1 | Write control; high blocks writing |
| sda_oe | output | 1 | High pulls SDA low (acknowledge drive) |
| rd_addr | input | ADDR_W | Inspection read address into the array |
| rd_data | output | 8 | Array byte at rd_addr, combinational |

## Verification
Two functions can fall in the same clock cycle: write-control sampling and completion of the second address byte. The bench raises write-control at the same instant it drops SCL at the end of the eighth bit of the low address byte. Because both signals pass through synchronizers of equal depth, the write-control level and the byte-completing SCL fall arrive together. The refusal must still take effect: every data byte must get a NoAck and the row must read back unchanged. A second run raises write-control one bit later, and there the data must be acknowledged and written.

// File: rtl/eew_pkg.sv
`timescale 1ns/1ps
package eew_pkg;
  localparam int PAGE_W = 6;
  localparam logic [7:0] SEL_MASK = 8'hF1;
  localparam logic [7:0] SEL_WRITE = 8'hA0;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_DATA, S_SKIP
  } eew_state_t;

  function automatic logic dev_code_ok(input logic [7:0] b);
    return (b & SEL_MASK) == SEL_WRITE;
  endfunction

  function automatic logic [PAGE_W-1:0] page_inc(input logic [PAGE_W-1:0] off);
    return off + 1'b1;
  endfunction
endpackage

// File: rtl/eew_bus_sync.sv
`timescale 1ns/1ps
module eew_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic sda_s,
  output logic wc_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LANES = 3;
  localparam logic [LANES-1:0] IDLE_VAL = 3'b011;

  logic [LANES-1:0] pipe [STAGES];
  logic [1:0] last;
  logic [LANES-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= IDLE_VAL;
      last <= 2'b11;
    end else begin
      pipe[0] <= {wc_i, sda_i, scl_i};
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      last <= pipe[STAGES-1][1:0];
    end
  end

  assign cur      = pipe[STAGES-1];
  assign sda_s    = cur[1];
  assign wc_s     = cur[2];
  assign scl_rise = cur[0] & ~last[0];
  assign scl_fall = ~cur[0] & last[0];
  assign start_ev = cur[0] & last[0] & last[1] & ~cur[1];
  assign stop_ev  = cur[0] & last[0] & ~last[1] & cur[1];
endmodule

// File: rtl/eew_proto.sv
`timescale 1ns/1ps
module eew_proto import eew_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int ROW_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic              wc_s,
  output logic              sda_oe,
  output logic              byte_done,
  output logic              wp,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_idx,
  output logic [7:0]        buf_data,
  output logic [ROW_W-1:0]  row,
  output eew_state_t        st,
  output logic [7:0]        shreg,
  output logic              commit_req,
  output logic              discard
);
  logic [3:0]        cnt;
  logic [ADDR_W-9:0] hi_q;
  logic [PAGE_W-1:0] off;
  logic              pending;
  logic [ADDR_W-1:0] addr_w;
  logic              active, addr_phase, tail_ok;

  assign active     = (st == S_DEV) || (st == S_AHI) || (st == S_ALO) || (st == S_DATA);
  assign addr_phase = (st == S_DEV) || (st == S_AHI) || (st == S_ALO);
  assign byte_done  = active && scl_fall && (cnt == 4'd8);
  assign buf_we     = byte_done && (st == S_DATA) && !wp;
  assign buf_idx    = off;
  assign buf_data   = shreg;
  assign addr_w     = {hi_q, shreg};
  assign tail_ok    = (cnt <= 4'd1) || (cnt == 4'd9);
  assign commit_req = stop_ev && (st == S_DATA) && pending && tail_ok;
  assign discard    = start_ev || (stop_ev && !commit_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sda_oe  <= 1'b0;
      wp      <= 1'b0;
      pending <= 1'b0;
      shreg   <= '0;
      hi_q    <= '0;
      row     <= '0;
      off     <= '0;
    end else if (start_ev) begin
      st      <= S_DEV;
      cnt     <= '0;
      sda_oe  <= 1'b0;
      wp      <= wc_s;
      pending <= 1'b0;
    end else if (stop_ev) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sda_oe  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (addr_phase && wc_s) wp <= 1'b1;
      if (active && scl_rise) begin
        if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        if (cnt < 4'd9) cnt <= cnt + 4'd1;
      end
      if (active && scl_fall) begin
        if (cnt == 4'd9) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
        end else if (cnt == 4'd8) begin
          case (st)
            S_DEV: begin
              if (dev_code_ok(shreg)) begin
                sda_oe <= 1'b1;
                st     <= S_AHI;
              end else begin
                st <= S_SKIP;
              end
            end
            S_AHI: begin
              hi_q   <= shreg[ADDR_W-9:0];
              sda_oe <= 1'b1;
              st     <= S_ALO;
            end
            S_ALO: begin
              row    <= addr_w[ADDR_W-1:PAGE_W];
              off    <= addr_w[PAGE_W-1:0];
              sda_oe <= 1'b1;
              st     <= S_DATA;
            end
            S_DATA: begin
              if (!wp) begin
                sda_oe  <= 1'b1;
                pending <= 1'b1;
                off     <= page_inc(off);
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/eew_page_buf.sv
`timescale 1ns/1ps
module eew_page_buf import eew_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int ROW_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [7:0]        buf_data,
  input  logic [ROW_W-1:0]  row,
  input  logic              commit_req,
  input  logic              discard,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              commit_busy
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]        slots [PAGE];
  logic [PAGE-1:0]   valid, valid_nx;
  logic [PAGE_W-1:0] cidx;
  logic [ROW_W-1:0]  crow;

  always_comb begin
    valid_nx = valid;
    if (discard && !commit_busy) valid_nx = '0;
    if (commit_busy) valid_nx[cidx] = 1'b0;
    if (buf_we) valid_nx[buf_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) slots[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid       <= '0;
      cidx        <= '0;
      crow        <= '0;
      commit_busy <= 1'b0;
    end else begin
      valid <= valid_nx;
      if (commit_req) begin
        commit_busy <= 1'b1;
        cidx        <= '0;
        crow        <= row;
      end else if (commit_busy) begin
        cidx <= cidx + 1'b1;
        if (cidx == {PAGE_W{1'b1}}) commit_busy <= 1'b0;
      end
    end
  end

  assign mem_we    = commit_busy && valid[cidx];
  assign mem_addr  = {crow, cidx};
  assign mem_wdata = slots[cidx];
endmodule

// File: rtl/eew_array.sv
`timescale 1ns/1ps
module eew_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eew_top.sv
`timescale 1ns/1ps
module eew_top import eew_pkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wc_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic sda_s, wc_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_done, wp, buf_we, commit_req, discard;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0] buf_data, shreg;
  logic [ROW_W-1:0] row;
  eew_state_t st;
  logic mem_we, commit_busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  eew_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wc_i(wc_i),
    .sda_s(sda_s), .wc_s(wc_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eew_proto #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s), .wc_s(wc_s),
    .sda_oe(sda_oe), .byte_done(byte_done), .wp(wp), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_data(buf_data), .row(row), .st(st),
    .shreg(shreg), .commit_req(commit_req), .discard(discard)
  );

  eew_page_buf #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_data(buf_data), .row(row), .commit_req(commit_req),
    .discard(discard), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .commit_busy(commit_busy)
  );

  eew_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/eew_checker.sv
`timescale 1ns/1ps
module eew_checker import eew_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       byte_done,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input eew_state_t st,
  input logic [7:0] shreg,
  input logic       wp,
  input logic       commit_busy
);
  localparam int PAGE = 1 << PAGE_W;
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else if (commit_busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R10: the acknowledge drive starts only right after a byte completes
  a_r10_oe_rise_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(byte_done));

  // R10: the drive is released only at an SCL fall or a bus condition
  a_r10_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

  a_r1_bad_select_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_DEV && !dev_code_ok(shreg)) |=> !sda_oe);

  a_r2_addr_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == S_AHI || st == S_ALO)) |=> sda_oe);

  a_r7_protected_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_DATA && wp) |=> !sda_oe);

  a_r9_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_busy) |-> $past(stop_ev));

  always @(posedge clk) begin
    if (rst_n) begin
      a_r9_commit_bounded: assert (busy_run <= PAGE);
    end
  end
endmodule

bind eew_top eew_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .byte_done(byte_done),
  .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev), .st(st),
  .shreg(shreg), .wp(wp), .commit_busy(commit_busy)
);

// File: tb/eew_top_tb.sv
`timescale 1ns/1ps
module eew_top_tb;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_sda, wc, sda_oe;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, r10_viol = 0;
  bit ack_win = 1'b0, finished = 1'b0;
  logic [7:0] model [int];

  eew_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .wc_i(wc),
    .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (rst_n && !ack_win && sda_oe) r10_viol++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit wc_fall, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H);
      m_scl = 1'b1; tick(H);
      if (i == 0) begin
        ack_win = 1'b1;
        if (wc_fall) wc = 1'b1;
      end
      m_scl = 1'b0; tick(H);
    end
    m_sda = 1'b1;
    m_scl = 1'b1; tick(H / 2);
    ack = sda_oe;
    tick(H / 2);
    m_scl = 1'b0; tick(H);
    ack_win = 1'b0;
  endtask

  task automatic verify_row(input logic [15:0] a, input string tag);
    int base;
    base = int'(a) & (DEPTH - 1) & ~63;
    for (int k = 0; k < 64; k++) begin
      if (model.exists(base + k)) begin
        rd_addr = AW'(base + k);
        tick(1);
        chk($sformatf("%s read %0h", tag, base + k), rd_data, model[base + k]);
      end
    end
  endtask

  // wcm: 0 low, 1 high from before START, 2 rises with the byte-ending fall of
  // the low address byte, 3 rises after the address phase.
  // term: 0 STOP, 1 repeated START then STOP, 2 three bits then STOP.
  task automatic xfer(input logic [15:0] a, input logic [7:0] d[$], input int wcm,
                      input int term, input logic [7:0] dev, input string tag);
    bit ack, sel_ok, prot;
    int idx;
    sel_ok = ((dev & 8'hF1) == 8'hA0);
    prot = (wcm == 1) || (wcm == 2);
    idx = int'(a) & (DEPTH - 1);
    wc = (wcm == 1);
    tick(4);
    bus_start();
    send_byte(dev, 1'b0, ack);
    chk({tag, " R1 select ack"}, ack, sel_ok);
    send_byte(a[15:8], 1'b0, ack);
    chk({tag, " R2 high address ack"}, ack, sel_ok);
    send_byte(a[7:0], wcm == 2, ack);
    chk({tag, " R2 low address ack"}, ack, sel_ok);
    if (wcm == 3) wc = 1'b1;
    foreach (d[i]) begin
      send_byte(d[i], 1'b0, ack);
      chk($sformatf("%s R4 R7 data ack %0d", tag, i), ack, sel_ok && !prot);
    end
    if (model.exists(idx)) begin
      rd_addr = AW'(idx);
      tick(1);
      chk({tag, " R9 unchanged before STOP"}, rd_data, model[idx]);
    end
    if (term == 1) begin
      bus_start();
    end else if (term == 2) begin
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    end
    bus_stop();
    tick(72);
    if (term == 0 && sel_ok && !prot) begin
      foreach (d[i]) model[(idx & ~63) | ((idx + i) & 63)] = d[i];
    end
    wc = 1'b0;
    verify_row(a, tag);
  endtask

  initial begin
    #750us;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    bit ack;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; wc = 1'b0; rd_addr = '0;
    tick(10);
    rst_n = 1'b1;
    tick(5);
    chk("R11 reset sda_oe", sda_oe, 1'b0);
    send_byte(8'hA0, 1'b0, ack);
    chk("R11 no ack before START", ack, 1'b0);

    q = {8'h5A};
    xfer(16'h0123, q, 0, 0, 8'hA0, "R3 byte write");
    q = {};
    for (int i = 0; i < 8; i++) q.push_back(8'(8'h10 + i));
    xfer(16'h0200, q, 0, 0, 8'hA0, "R4 page write");
    q = {};
    for (int i = 0; i < 6; i++) q.push_back(8'(8'hC0 + i));
    xfer(16'h027C, q, 0, 0, 8'hA0, "R5 row wrap");
    q = {};
    for (int i = 0; i < 70; i++) q.push_back(8'(i * 3 + 1));
    xfer(16'h0300, q, 0, 0, 8'hA0, "R5 overwrite");
    q = {8'hA7};
    xfer(16'hC123, q, 0, 0, 8'hA0, "R6 high bits");

    q = {8'hEE, 8'hEF};
    xfer(16'h0200, q, 0, 0, 8'hB0, "R1 wrong code");
    xfer(16'h0200, q, 0, 0, 8'hA1, "R1 read bit");
    xfer(16'h0200, q, 0, 0, 8'hAE, "R1 ignored bits");
    q = {8'hEE, 8'hEF};
    xfer(16'h0201, q, 1, 0, 8'hA0, "R7 wc from start");
    xfer(16'h0202, q, 2, 0, 8'hA0, "R7 wc same cycle");
    q = {8'h77, 8'h78, 8'h79};
    xfer(16'h0200, q, 3, 0, 8'hA0, "R7 wc late");

    q = {8'h99, 8'h98};
    xfer(16'h0203, q, 0, 1, 8'hA0, "R8 repeated start");
    xfer(16'h0204, q, 0, 2, 8'hA0, "R8 partial byte");

    chk("R10 ack window violations", r10_viol, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule